// File: doc/BRIEF.md
# Undervoltage Reset Sequencer

This block generates an active-low reset for a microcontroller from a digital undervoltage flag. The flag is the sampled output of a supply comparator: high means the supply is below its threshold. The flag crosses into the clock domain through a flop synchronizer. A run-length filter then rejects brief dips. The reset output stays asserted for a fixed release delay each time the supply comes back.

The release delay is built from a coarse timebase. A prescaler divides the clock by `TICK_DIV`, and a tick counter counts `DELAY_TICKS` of those ticks. The whole delay is therefore `TICK_DIV * DELAY_TICKS` clock cycles, 6400 with the defaults.

A synchronous request input, for example from a watchdog, starts the same release sequence as a qualified supply dip. A busy output shows whether a reset sequence is still in progress.

Top module: `uv_reset_seq`

In the requirements, N = `TICK_DIV * DELAY_TICKS`, R = `REACT_CYCLES`, and "edge k" is the k-th rising clock edge.

## Requirements
- R1: While `porClearN` is low and right after it is released, `mcuResetN` is 0 and `resetBusy` is 1.
- R2: While the synchronized flag reads 1 (supply low), `mcuResetN` stays 0 no matter how long the condition lasts.
- R3: If edge a is the first edge to sample `supplyLowIn` = 0 after a qualified loss or power-on, `mcuResetN` rises at edge a+2+N. This timing follows from the two synchronizer stages plus N delay cycles.
- R4: A run of fewer than R consecutive samples of `supplyLowIn` = 1 leaves the output unchanged. A single sample of 0 clears the run count, so short runs never add up.
- R5: If `supplyLowIn` is sampled 1 on R consecutive edges starting at edge a, `mcuResetN` falls at edge a+R+1 if it was high.
- R6: After a qualified dip, the full delay N is counted again from the moment the supply is valid, with the timing of R3.
- R7: A qualified dip during a release delay abandons that delay. Reset then rises only N+2 edges after the supply is sampled valid again.
- R8: When `resetReq` is sampled 1 at edge a while the supply is not lost, `mcuResetN` is 0 from edge a and rises at edge a+N. A request during a running delay restarts it.
- R9: `resetReq` has no effect while the supply is lost; release still follows R3.
- R10: `resetBusy` is always the inverse of `mcuResetN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porClearN | input | 1 | Asynchronous power-on clear, active low |
| supplyLowIn | input | 1 | Undervoltage flag, 1 = supply below threshold (asynchronous) |
| resetReq | input | 1 | Synchronous request for a reset sequence, active high |
| mcuResetN | output | 1 | Microcontroller reset, active low |
| resetBusy | output | 1 | High while a reset sequence is in progress |

## Verification
The hardest situation to reach is a dip or a request that lands inside an already-running release delay. In that case the output level does not change, and only the later rise time shows whether the delay restarted. The bench starts a delay with a request and then, partway through, applies either a second request, a qualifying dip or a sub-threshold dip. For each case it predicts the exact rise edge. It also applies a request in the middle of a long dip and checks that the release timing is unaffected.

// File: rtl/uv_reset_pkg.sv
package uv_reset_pkg;

  typedef enum logic [1:0] {
    ST_LOST  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } seqStateT;

  // control -> datapath
  typedef struct packed {
    logic clrDelay;
    logic runDelay;
  } seqStrobeT;

  // datapath -> control
  typedef struct packed {
    logic lowSync;
    logic dipQual;
    logic delayDone;
  } seqStatusT;

endpackage

// File: rtl/uv_reset_datapath.sv
module uv_reset_datapath
  import uv_reset_pkg::*;
#(
  parameter int REACT_CYCLES = 16,
  parameter int TICK_DIV     = 100,
  parameter int DELAY_TICKS  = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic      clk,
  input  logic      porClearN,
  input  logic      supplyLowIn,
  input  seqStrobeT strobe,
  output seqStatusT status
);

  localparam int REACT_W = $clog2(REACT_CYCLES + 1);
  localparam int PRE_W   = $clog2(TICK_DIV + 1);
  localparam int DLY_W   = $clog2(DELAY_TICKS + 1);
  localparam logic [REACT_W-1:0] REACT_MAX = REACT_W'(REACT_CYCLES - 1);
  localparam logic [PRE_W-1:0]   PRE_MAX   = PRE_W'(TICK_DIV - 1);
  localparam logic [DLY_W-1:0]   DLY_MAX   = DLY_W'(DELAY_TICKS - 1);

  // synchronizer; reset value assumes the supply is low
  logic [SYNC_STAGES-1:0] syncChain;
  logic lowSync;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge porClearN) begin
        if (!porClearN) syncChain <= '1;
        else            syncChain <= supplyLowIn;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge porClearN) begin
        if (!porClearN) syncChain <= '1;
        else            syncChain <= {syncChain[SYNC_STAGES-2:0], supplyLowIn};
      end
    end
  endgenerate

  assign lowSync = syncChain[SYNC_STAGES-1];

  // reaction-time run-length filter
  logic [REACT_W-1:0] reactCnt;
  logic dipQual;

  always_ff @(posedge clk or negedge porClearN) begin
    if (!porClearN)              reactCnt <= '0;
    else if (!lowSync)           reactCnt <= '0;
    else if (reactCnt != REACT_MAX) reactCnt <= reactCnt + 1'b1;
  end

  assign dipQual = lowSync && (reactCnt == REACT_MAX);

  // release delay: prescaler and tick counter
  logic [PRE_W-1:0] preCnt;
  logic [DLY_W-1:0] tickCnt;
  logic tickNow;

  assign tickNow = strobe.runDelay && (preCnt == PRE_MAX);

  always_ff @(posedge clk or negedge porClearN) begin
    if (!porClearN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.clrDelay) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.runDelay) begin
      if (tickNow) begin
        preCnt <= '0;
        if (tickCnt != DLY_MAX) tickCnt <= tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign status.lowSync   = lowSync;
  assign status.dipQual   = dipQual;
  assign status.delayDone = tickNow && (tickCnt == DLY_MAX);

  // R4: a valid sample always empties the run-length filter
  a_r4_filter_clears: assert property (@(posedge clk) disable iff (!porClearN)
    !lowSync |=> (reactCnt == '0));

  // R4: filter never qualifies before R consecutive low samples
  a_r4_no_early_qual: assert property (@(posedge clk) disable iff (!porClearN)
    (lowSync && reactCnt != REACT_MAX) |-> !dipQual);

  // R3: prescaler wraps after its last count
  a_r3_prescale_wrap: assert property (@(posedge clk) disable iff (!porClearN)
    (strobe.runDelay && !strobe.clrDelay && preCnt == PRE_MAX) |=> (preCnt == '0));

  // R3: counters stay inside their ranges
  a_r3_counter_range: assert property (@(posedge clk) disable iff (!porClearN)
    (preCnt <= PRE_MAX) && (tickCnt <= DLY_MAX));

endmodule

// File: rtl/uv_reset_ctrl.sv
module uv_reset_ctrl
  import uv_reset_pkg::*;
(
  input  logic      clk,
  input  logic      porClearN,
  input  logic      resetReq,
  input  seqStatusT status,
  output seqStrobeT strobe,
  output logic      mcuResetN,
  output logic      resetBusy
);

  seqStateT state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LOST: begin
        if (!status.lowSync) stateNext = ST_DELAY;
      end
      ST_DELAY: begin
        if (status.dipQual)        stateNext = ST_LOST;
        else if (resetReq)         stateNext = ST_DELAY;
        else if (status.delayDone) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (status.dipQual) stateNext = ST_LOST;
        else if (resetReq)  stateNext = ST_DELAY;
      end
      default: stateNext = ST_LOST;
    endcase
  end

  always_ff @(posedge clk or negedge porClearN) begin
    if (!porClearN) state <= ST_LOST;
    else            state <= stateNext;
  end

  // counters held clear outside the delay; a request inside it restarts it
  assign strobe.clrDelay = (state != ST_DELAY) || resetReq;
  assign strobe.runDelay = (state == ST_DELAY);

  assign mcuResetN = (state == ST_RUN);
  assign resetBusy = (state != ST_RUN);

  // R2: lost supply keeps the sequencer parked while the flag stays low
  a_r2_hold_lost: assert property (@(posedge clk) disable iff (!porClearN)
    (state == ST_LOST && status.lowSync) |=> (state == ST_LOST));

  // R5: a qualified dip always drops into the lost state
  a_r5_dip_drops: assert property (@(posedge clk) disable iff (!porClearN)
    status.dipQual |=> (state == ST_LOST));

  // R8: a request outside the lost state (and without a dip) starts the delay
  a_r8_req_restarts: assert property (@(posedge clk) disable iff (!porClearN)
    (resetReq && state != ST_LOST && !status.dipQual) |=> (state == ST_DELAY));

  // R9: a request cannot leave the lost state while the flag stays low
  a_r9_req_ignored: assert property (@(posedge clk) disable iff (!porClearN)
    (resetReq && state == ST_LOST && status.lowSync) |=> (state == ST_LOST));

  // R3: release happens only when the delay completes
  a_r3_release_gate: assert property (@(posedge clk) disable iff (!porClearN)
    $rose(mcuResetN) |-> $past(status.delayDone));

endmodule

// File: rtl/uv_reset_seq.sv
module uv_reset_seq
  import uv_reset_pkg::*;
#(
  parameter int REACT_CYCLES = 16,
  parameter int TICK_DIV     = 100,
  parameter int DELAY_TICKS  = 64
) (
  input  logic clk,
  input  logic porClearN,
  input  logic supplyLowIn,
  input  logic resetReq,
  output logic mcuResetN,
  output logic resetBusy
);

  seqStrobeT strobe;
  seqStatusT status;

  uv_reset_datapath #(
    .REACT_CYCLES(REACT_CYCLES),
    .TICK_DIV    (TICK_DIV),
    .DELAY_TICKS (DELAY_TICKS),
    .SYNC_STAGES (2)
  ) uDatapath (
    .clk        (clk),
    .porClearN  (porClearN),
    .supplyLowIn(supplyLowIn),
    .strobe     (strobe),
    .status     (status)
  );

  uv_reset_ctrl uCtrl (
    .clk      (clk),
    .porClearN(porClearN),
    .resetReq (resetReq),
    .status   (status),
    .strobe   (strobe),
    .mcuResetN(mcuResetN),
    .resetBusy(resetBusy)
  );

  // R10: busy is the complement of the reset pin
  always_comb begin
    a_r10_busy_inverse: assert (resetBusy == !mcuResetN);
  end

endmodule

// File: tb/tb_uv_reset_seq.sv
module tb_uv_reset_seq;

  localparam int REACT = 4;
  localparam int TDIV  = 5;
  localparam int DTCK  = 6;
  localparam int N     = TDIV * DTCK;

  logic clk = 1'b0;
  logic porClearN;
  logic supplyLowIn;
  logic resetReq;
  logic mcuResetN;
  logic resetBusy;

  uv_reset_seq #(
    .REACT_CYCLES(REACT),
    .TICK_DIV    (TDIV),
    .DELAY_TICKS (DTCK)
  ) dut (
    .clk        (clk),
    .porClearN  (porClearN),
    .supplyLowIn(supplyLowIn),
    .resetReq   (resetReq),
    .mcuResetN  (mcuResetN),
    .resetBusy  (resetBusy)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  lvl;
    string req;
  } expT;

  expT sbq[$];
  expT popped;
  logic prevN = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int at, input logic lvl, input string req);
    expT e;
    e.at = at; e.lvl = lvl; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dip(input int w);
    supplyLowIn = 1'b1;
    waitCyc(w);
    supplyLowIn = 1'b0;
  endtask

  task automatic pulseReq();
    resetReq = 1'b1;
    @(negedge clk);
    resetReq = 1'b0;
  endtask

  // monitor: every change of the reset pin must match the head of the queue
  always @(negedge clk) begin
    if (porClearN && !finished && (mcuResetN !== prevN)) begin
      if (sbq.size() == 0) begin
        check(1'b0, "unexpected edge", int'(mcuResetN), int'(prevN));
      end else begin
        popped = sbq.pop_front();
        check(cyc == popped.at, {popped.req, " edge cycle"}, cyc, popped.at);
        check(mcuResetN === popped.lvl, {popped.req, " edge level"},
              int'(mcuResetN), int'(popped.lvl));
        check(resetBusy === !mcuResetN, "R10 busy", int'(resetBusy), int'(!mcuResetN));
      end
      prevN = mcuResetN;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int c;
    int c2;
    porClearN   = 1'b0;
    supplyLowIn = 1'b1;
    resetReq    = 1'b0;
    waitCyc(3);
    // R1: state during clear
    check(mcuResetN === 1'b0, "R1 reset pin", int'(mcuResetN), 0);
    check(resetBusy === 1'b1, "R1 busy", int'(resetBusy), 1);
    porClearN = 1'b1;
    waitCyc(1);
    check(mcuResetN === 1'b0, "R1 after clear", int'(mcuResetN), 0);

    // R2: supply low for a long time keeps reset low
    waitCyc(60);
    check(mcuResetN === 1'b0, "R2 held low", int'(mcuResetN), 0);

    // R3: first release after power-up
    c = cyc;
    push(c + 3 + N, 1'b1, "R3");
    supplyLowIn = 1'b0;
    waitCyc(N + 10);
    check(mcuResetN === 1'b1, "R3 released", int'(mcuResetN), 1);

    // R4: sub-threshold dip
    dip(REACT - 1);
    waitCyc(20);
    check(mcuResetN === 1'b1, "R4 short dip", int'(mcuResetN), 1);
    // R4: two short runs split by one valid sample
    dip(REACT - 1);
    waitCyc(1);
    dip(REACT - 1);
    waitCyc(20);
    check(mcuResetN === 1'b1, "R4 split dips", int'(mcuResetN), 1);

    // R5 / R6: minimal qualified dip, then full delay
    c = cyc;
    push(c + 2 + REACT, 1'b0, "R5");
    push(c + REACT + 3 + N, 1'b1, "R6");
    dip(REACT);
    waitCyc(N + 10);
    check(mcuResetN === 1'b1, "R6 back high", int'(mcuResetN), 1);

    // R9: request during a long dip does not shorten release
    c = cyc;
    push(c + 2 + REACT, 1'b0, "R5 long");
    push(c + 20 + 3 + N, 1'b1, "R9");
    supplyLowIn = 1'b1;
    waitCyc(10);
    pulseReq();
    waitCyc(9);
    supplyLowIn = 1'b0;
    waitCyc(N + 10);

    // R8: request from run, second request restarts
    c = cyc;
    push(c + 1, 1'b0, "R8 assert");
    pulseReq();
    waitCyc(10);
    c2 = cyc;
    push(c2 + 1 + N, 1'b1, "R8 restart");
    pulseReq();
    waitCyc(N + 10);

    // R7: qualified dip inside a delay
    c = cyc;
    push(c + 1, 1'b0, "R7 assert");
    pulseReq();
    waitCyc(10);
    c2 = cyc;
    push(c2 + 6 + 3 + N, 1'b1, "R7");
    dip(6);
    waitCyc(N + 10);

    // R4: short dip inside a delay leaves its timing unchanged
    c = cyc;
    push(c + 1, 1'b0, "R8 again");
    push(c + 1 + N, 1'b1, "R4 in delay");
    pulseReq();
    waitCyc(5);
    dip(REACT - 1);
    waitCyc(N + 10);

    check(sbq.size() == 0, "R3 all edges seen", sbq.size(), 0);
    check(resetBusy === 1'b0, "R10 idle busy", int'(resetBusy), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule